// File: doc/BRIEF.md
# Strobe-Ordered DRAM Command Decoder

This block is a clock-sampled model of the control logic inside a multiplexed-address dynamic RAM. On every clock it samples the active-low row strobe, column strobe, write enable and output enable, together with the shared address pins. It decides what kind of memory cycle is running from the order in which the strobe edges arrive. The possible cycles are a read, an early write, a row-address-only refresh, a column-first refresh, and entry into a compressed test mode. A small register array stands in for the cell array. Its row index is taken from the low address bits latched at the row strobe, and its column index from the low address bits latched at the column strobe.

An 11-bit internal counter supplies the row for column-first refreshes. Every refresh shows up as a one-cycle strobe on `ref_stb` together with the refreshed row on `ref_row`, so a surrounding model or a bench can follow refresh activity. The test mode stays latched across ordinary cycles. While it is active, each data bit is written into a group of four neighbouring columns at once. A test read returns, for each data bit, a flag that tells whether the four cells of the group agree.

Top module: `strobe_dram_core`

## Requirements
- R1: After reset, `test_mode`, `ref_stb` and `dq_oe` are 0, and the refresh counter holds 0, so the first column-first refresh reports row 0.
- R2: When `cas_n` is already low at the clock where a falling `ras_n` is first sampled, and `we_n` is high, the block performs a refresh. In the following cycle `ref_stb` is 1 for one cycle and `ref_row` equals the counter value, and the counter then advances by one.
- R3: The refresh counter is `ADDR_W` bits wide (11 by default). After reporting 2047 it next reports 0.
- R4: When `cas_n` and `we_n` are both low as the `ras_n` fall is sampled, the cycle is refreshed and counted as in R2, and `test_mode` becomes 1. The mode holds through any number of read and write cycles.
- R5: Either a column-first refresh with `we_n` high or a row-address-only refresh returns `test_mode` to 0.
- R6: A row-strobe cycle with no column strobe fall refreshes the row on the address pins. In the cycle after the `ras_n` rise is sampled, `ref_stb` is 1 and `ref_row` equals the address latched at the `ras_n` fall. `dq_oe` stays 0 during the cycle, and the refresh counter is unchanged. A cycle in which the column strobe did fall produces no refresh pulse.
- R7: In an early write, `we_n` is low when the `cas_n` fall is sampled. `dq_in` is then stored at word index {row bits [ROW_W-1:0], column bits [COL_W-1:0]}, and `dq_oe` stays 0.
- R8: In a read, `we_n` is high at the `cas_n` fall. `dq_oe` is 1 exactly while `cas_n`, `oe_n` and `ras_n` stay low and `we_n` stays high. `dq_out` then shows the stored word. With `oe_n` high, `dq_oe` is 0.
- R9: A test-mode write ignores column bits [1:0] and writes `dq_in` to all four words that share the remaining column bits.
- R10: In a test-mode read, `dq_out[b]` is 1 when bit b is equal in all four words of the addressed group, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DQ_W | Write data |
| dq_out | output | DQ_W | Read data, 0 when not driven |
| dq_oe | output | 1 | Output driver enable; 0 means high impedance |
| test_mode | output | 1 | Compressed test mode latched |
| ref_stb | output | 1 | One-cycle refresh indication |
| ref_row | output | ADDR_W | Row refreshed with the current `ref_stb` |

## Verification
The assertions check on every cycle that a column-first refresh pulses with the counter's running value, including across the wrap. They also check that test mode is entered and left only on the strobe edges that decide it, and that the output never stays enabled once the row strobe has been high for two samples. Only the bench scenarios can show the contents of the array. That covers the sweep of early writes and reads over every word, the fan-out of a test write to four columns, and the agree/disagree flags after a cell in a group has been changed in normal mode. The rule that a row-only refresh leaves the counter alone is shown by the next column-first refresh.

// File: rtl/strobe_dram_core.sv
module strobe_dram_core #(
  parameter int ADDR_W = 11,
  parameter int ROW_W  = 2,
  parameter int COL_W  = 3,
  parameter int GRP_W  = 2,
  parameter int DQ_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq_in,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic              test_mode,
  output logic              ref_stb,
  output logic [ADDR_W-1:0] ref_row
);
  localparam int AW    = ROW_W + COL_W;
  localparam int DEPTH = 1 << AW;
  localparam int GRP   = 1 << GRP_W;

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_CBR} st_t;

  st_t               st;
  logic              ras_q, cas_q, saw_cas, rd_act;
  logic [ADDR_W-1:0] row_q, rcnt;
  logic [COL_W-1:0]  col_q;
  logic [DQ_W-1:0]   mem [DEPTH];
  logic [DQ_W-1:0]   rd_word;

  wire ras_fall = ras_q & ~ras_n;
  wire ras_rise = ~ras_q & ras_n;
  wire cas_fall = cas_q & ~cas_n;
  wire cas_rise = ~cas_q & cas_n;
  wire wr_en    = (st == S_ACT) & ~ras_n & cas_fall & ~we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ras_q     <= 1'b1;
      cas_q     <= 1'b1;
      saw_cas   <= 1'b0;
      rd_act    <= 1'b0;
      row_q     <= '0;
      col_q     <= '0;
      rcnt      <= '0;
      test_mode <= 1'b0;
      ref_stb   <= 1'b0;
      ref_row   <= '0;
    end else begin
      ras_q   <= ras_n;
      cas_q   <= cas_n;
      ref_stb <= 1'b0;
      if (ras_fall) begin
        if (!cas_n) begin
          st        <= S_CBR;
          ref_stb   <= 1'b1;
          ref_row   <= rcnt;
          rcnt      <= rcnt + 1'b1;
          test_mode <= ~we_n;
        end else begin
          st      <= S_ACT;
          row_q   <= addr;
          saw_cas <= 1'b0;
        end
      end else if (ras_rise) begin
        if (st == S_ACT && !saw_cas) begin
          ref_stb   <= 1'b1;
          ref_row   <= row_q;
          test_mode <= 1'b0;
        end
        st     <= S_IDLE;
        rd_act <= 1'b0;
      end else if (st == S_ACT) begin
        if (cas_fall) begin
          col_q   <= addr[COL_W-1:0];
          saw_cas <= 1'b1;
          rd_act  <= we_n;
        end else if (cas_rise) begin
          rd_act <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (test_mode) begin
        for (int k = 0; k < GRP; k++)
          mem[{row_q[ROW_W-1:0], addr[COL_W-1:GRP_W], GRP_W'(k)}] <= dq_in;
      end else begin
        mem[{row_q[ROW_W-1:0], addr[COL_W-1:0]}] <= dq_in;
      end
    end
  end

  always_comb begin
    if (test_mode) begin
      rd_word = '1;
      for (int k = 1; k < GRP; k++)
        for (int b = 0; b < DQ_W; b++)
          if (mem[{row_q[ROW_W-1:0], col_q[COL_W-1:GRP_W], GRP_W'(k)}][b] !=
              mem[{row_q[ROW_W-1:0], col_q[COL_W-1:GRP_W], GRP_W'(0)}][b])
            rd_word[b] = 1'b0;
    end else begin
      rd_word = mem[{row_q[ROW_W-1:0], col_q}];
    end
  end

  assign dq_oe  = rd_act & ~cas_n & ~oe_n & we_n;
  assign dq_out = dq_oe ? rd_word : '0;
endmodule

// File: rtl/strobe_dram_core_chk.sv
module strobe_dram_core_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              dq_oe,
  input logic              test_mode,
  input logic              ref_stb,
  input logic [ADDR_W-1:0] ref_row
);
  logic              ras_p;
  logic [ADDR_W-1:0] cnt_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_p <= 1'b1;
      cnt_m <= '0;
    end else begin
      ras_p <= ras_n;
      if (ras_p && !ras_n && !cas_n) cnt_m <= cnt_m + 1'b1;
    end
  end

  AST_CBR_PULSE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_p && !ras_n && !cas_n) |=> (ref_stb && ref_row == $past(cnt_m))); // R2

  AST_TEST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_p && !ras_n && !cas_n && !we_n) |=> test_mode); // R4

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n == ras_p) |=> $stable(test_mode)); // R4

  AST_CBR_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_p && !ras_n && !cas_n && we_n) |=> !test_mode); // R5

  AST_OE_RAS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && ras_p) |-> !dq_oe); // R8
endmodule

bind strobe_dram_core strobe_dram_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .dq_oe(dq_oe), .test_mode(test_mode), .ref_stb(ref_stb), .ref_row(ref_row)
);

// File: tb/test_strobe_dram_core.sv
module test_strobe_dram_core;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [10:0] addr = '0;
  logic [3:0]  dq_in = '0;
  logic [3:0]  dq_out;
  logic        dq_oe, test_mode, ref_stb;
  logic [10:0] ref_row;

  int          vecs = 0, errs = 0;
  logic [10:0] exp_cnt = '0;
  logic [3:0]  mdl [32];

  always #(CLK_P/2) clk = ~clk;

  strobe_dram_core i_strobe_dram_core (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .test_mode(test_mode), .ref_stb(ref_stb), .ref_row(ref_row)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] grp_flag(int row, int chi);
    logic [3:0] f = 4'hF;
    for (int k = 1; k < 4; k++)
      for (int b = 0; b < 4; b++)
        if (mdl[row*8 + chi*4 + k][b] != mdl[row*8 + chi*4][b]) f[b] = 1'b0;
    return f;
  endfunction

  task automatic col_first(bit enter, logic exp_tm, string tag);
    tick(); cas_n = 1'b0; we_n = ~enter;
    tick(); ras_n = 1'b0;
    tick();
    chk({tag, " ref_stb"}, ref_stb, 1'b1);
    chk({tag, " ref_row"}, ref_row, exp_cnt);
    chk({tag, " test_mode"}, test_mode, exp_tm);
    exp_cnt++;
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    tick();
    chk({tag, " single pulse"}, ref_stb, 1'b0);
  endtask

  task automatic row_only(logic [10:0] r);
    tick(); ras_n = 1'b0; addr = r;
    tick();
    tick();
    chk("R6 hi-z during row-only", dq_oe, 1'b0);
    ras_n = 1'b1;
    tick();
    chk("R6 ref_stb", ref_stb, 1'b1);
    chk("R6 ref_row", ref_row, r);
    chk("R5 row-only exit", test_mode, 1'b0);
    tick();
  endtask

  task automatic wr(int r, int c, logic [3:0] d);
    tick(); ras_n = 1'b0; addr = 11'(r);
    tick(); cas_n = 1'b0; we_n = 1'b0; addr = 11'(c); dq_in = d;
    tick();
    chk("R7 no drive in write", dq_oe, 1'b0);
    cas_n = 1'b1; we_n = 1'b1;
    tick(); ras_n = 1'b1;
    tick();
    chk("R6 no refresh after column cycle", ref_stb, 1'b0);
  endtask

  task automatic rd(int r, int c, logic [3:0] e, string tag);
    tick(); ras_n = 1'b0; addr = 11'(r);
    tick(); cas_n = 1'b0; addr = 11'(c);
    tick();
    chk("R8 oe_n high gates output", dq_oe, 1'b0);
    oe_n = 1'b0;
    tick();
    chk("R8 dq_oe in read", dq_oe, 1'b1);
    chk(tag, dq_out, e);
    cas_n = 1'b1; oe_n = 1'b1;
    tick();
    chk("R8 release on cas rise", dq_oe, 1'b0);
    ras_n = 1'b1;
    tick();
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    errs++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 test_mode reset", test_mode, 1'b0);
    chk("R1 ref_stb reset", ref_stb, 1'b0);
    chk("R1 dq_oe reset", dq_oe, 1'b0);
    col_first(1'b0, 1'b0, "R1 R2 first refresh");

    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 8; c++) begin
        mdl[r*8 + c] = 4'((r*5 + c*3 + 1) & 15);
        wr(r, c, mdl[r*8 + c]);
      end
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 8; c++)
        rd(r, c, mdl[r*8 + c], "R7 R8 read back");

    row_only(11'h5A3);
    col_first(1'b0, 1'b0, "R6 counter kept by row-only");

    col_first(1'b1, 1'b1, "R4 test entry");
    for (int g = 0; g < 8; g++) begin
      for (int k = 0; k < 4; k++) mdl[g*4 + k] = 4'((g*3 + 2) & 15);
      wr(g / 2, (g % 2) * 4 + (g % 4), mdl[g*4]);
    end
    chk("R4 mode held", test_mode, 1'b1);
    for (int g = 0; g < 8; g++)
      rd(g / 2, (g % 2) * 4 + ((g + 1) % 4), grp_flag(g / 2, g % 2), "R9 R10 agree");
    chk("R4 mode held after reads", test_mode, 1'b1);

    col_first(1'b0, 1'b0, "R5 col-first exit");
    mdl[1] = mdl[1] ^ 4'b0101;
    wr(0, 1, mdl[1]);
    rd(0, 0, mdl[0], "R9 neighbour untouched");
    rd(0, 1, mdl[1], "R7 changed cell");
    col_first(1'b1, 1'b1, "R4 re-entry");
    rd(0, 2, grp_flag(0, 0), "R10 disagree");
    rd(1, 7, grp_flag(1, 1), "R10 other group");
    row_only(11'h012);

    for (int i = 0; i < 2050; i++)
      col_first(1'b0, 1'b0, "R3 counter sweep");

    finish_run();
  end
endmodule